// File: doc/BRIEF.md
# Dual-Channel Prescaled Pulse-Width Modulator

This block produces two pulse-width modulated outputs that software controls through a small word-addressed register port. Each channel divides the input clock with a 10-bit prescaler, counts prescaled ticks up to a 12-bit period limit, and drives its output active while the tick count is below a duty threshold. Per channel, software can set polarity, pick whether new settings wait for the end of the running period, choose between an abrupt and a graceful stop, and force an immediate reload.

Every register write first lands in a software-visible copy and then reaches the counters after a fixed number of cycles. This delay stands in for the hop into a separate PWM clock domain. While a value is in flight, a per-register busy flag in one shared status word is set. Software polls that word until the flag clears before it relies on the new setting. The register port has no stalls: a write is taken in the cycle `bus_wr` is high, and read data is a combinational function of `bus_addr`. The port is control-only and carries no valid/ready stream.

Top module: `pwm_duo`

## Requirements
- R1: The channel c register block starts at byte address 16·c and holds four words: control at +0x0, prescaler at +0x4, period at +0x8 and duty at +0xC. Reads return the last value written, masked to its width: prescaler 10 bits, period 12 bits, duty 12 bits, control bits 3:0. Control bits 5:4 always read as 0.
- R2: The channel slots at 0x20 and 0x30, and any address from 0x44 upward, read as 0 and ignore writes. In the status word at 0x40, every bit outside the implemented channels' flags reads as 0.
- R3: Status bit 8·c+k is the busy flag of channel c, register k (0 control, 1 prescaler, 2 period, 3 duty). The flag is set on the cycle after the write and stays set for exactly SYNC_LAT cycles, which is 3 by default.
- R4: While enabled, a channel repeats with a period of (prescaler+1)·(period+1) clocks. The output is active for duty·(prescaler+1) of those clocks when duty ≤ period.
- R5: A duty of 0 keeps the output inactive. A duty greater than the period value keeps it active.
- R6: Control bit 1 inverts the output. A stopped channel rests at its inactive level, which is high when bit 1 is set and low otherwise.
- R7: With control bit 2 set, new prescaler, period and duty values take effect only at a period rollover, so every active pulse has either the old width or the new width.
- R8: Control bit 0 enables the channel. When it is cleared with control bit 3 set, the output goes inactive within one cycle after the update lands. When bit 3 is clear, the current period finishes first.
- R9: A control write with bit 4 set reloads the prescaler at once. A control write with bit 5 set reloads period and duty at once and restarts the period. Both work even with bit 2 set.
- R10: The two channels are independent: configuring or running one never changes the other's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register port and the counters |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, taken in the same cycle |
| bus_addr | input | 7 | Byte address of the word; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pwm_out | output | NUM_CH | One modulated output per channel |

## Verification
The assertions check on every cycle that a busy flag rises after a write and falls right after its update lands, and that an autoloading channel holds its active settings between rollovers. They also check that an abrupt stop takes effect on the next cycle while a graceful stop keeps the channel running until the rollover. The status word's unused bits are checked to stay at zero. Only the bench's scenarios can show the whole waveform: active counts over whole periods, the duty boundaries, pulse widths while duty changes under autoload, how long a graceful stop takes, forced reloads, readback masking, and the isolation between channels.

// File: rtl/pwm_duo_pkg.sv
package pwm_duo_pkg;
  localparam int BUS_W    = 32;
  localparam int ADDR_W   = 7;
  localparam int SLOT_MAX = 4;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = 7'h40;

  typedef enum logic [1:0] {
    RG_CTRL  = 2'd0,
    RG_PRESC = 2'd1,
    RG_PER   = 2'd2,
    RG_DUTY  = 2'd3
  } reg_sel_e;

  // control word, bit 0 at the bottom
  typedef struct packed {
    logic ld_per;
    logic ld_presc;
    logic stop_now;
    logic autold;
    logic inv;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/pwm_duo_sync.sv
module pwm_duo_sync #(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic pending,
  output logic apply
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(LAT);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign pending = (cnt != '0);
  assign apply   = (cnt == CW'(1)) && !start;

  // R3
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> pending);
  // R3
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !apply) |=> pending);
  // R3
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> !pending);
endmodule

// File: rtl/pwm_duo_chan.sv
module pwm_duo_chan #(
  parameter int PRESC_W = 10,
  parameter int PER_W   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               inv,
  input  logic               autold,
  input  logic               stop_now,
  input  logic [PRESC_W-1:0] presc_in,
  input  logic [PER_W-1:0]   per_in,
  input  logic [PER_W-1:0]   duty_in,
  input  logic               ld_presc,
  input  logic               ld_per,
  output logic               pwm_o
);
  logic               running;
  logic [PRESC_W-1:0] pcnt, act_presc;
  logic [PER_W-1:0]   ccnt, act_per, act_duty;
  logic               tick, wrap;

  assign tick = running && (pcnt >= act_presc);
  assign wrap = tick && (ccnt >= act_per);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running   <= 1'b0;
      pcnt      <= '0;
      ccnt      <= '0;
      act_presc <= '0;
      act_per   <= '0;
      act_duty  <= '0;
    end else if (!running) begin
      pcnt      <= '0;
      ccnt      <= '0;
      act_presc <= presc_in;
      act_per   <= per_in;
      act_duty  <= duty_in;
      if (en) running <= 1'b1;
    end else if (!en && (stop_now || wrap)) begin
      running <= 1'b0;
      pcnt    <= '0;
      ccnt    <= '0;
    end else begin
      if (tick) pcnt <= '0;
      else      pcnt <= pcnt + 1'b1;
      if (wrap)      ccnt <= '0;
      else if (tick) ccnt <= ccnt + 1'b1;
      if (!autold || wrap) begin
        act_presc <= presc_in;
        act_per   <= per_in;
        act_duty  <= duty_in;
      end
      if (ld_presc) begin
        act_presc <= presc_in;
        pcnt      <= '0;
      end
      if (ld_per) begin
        act_per  <= per_in;
        act_duty <= duty_in;
        ccnt     <= '0;
        pcnt     <= '0;
      end
    end
  end

  assign pwm_o = inv ^ (running && (ccnt < act_duty));

  // R8
  stop_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !en && stop_now) |=> !running);
  // R8
  finish_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !en && !stop_now && !wrap) |=> running);
  // R7
  autoload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && en && autold && !wrap && !ld_per) |=> ($stable(act_duty) && $stable(act_per)));
endmodule

// File: rtl/pwm_duo.sv
module pwm_duo
  import pwm_duo_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int SYNC_LAT = 3,
  parameter int PRESC_W  = 10,
  parameter int PER_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [6:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int NREG = 4;

  function automatic logic [BUS_W-1:0] status_mask();
    logic [BUS_W-1:0] m = '0;
    for (int c = 0; c < NUM_CH; c++) m[8*c +: NREG] = '1;
    return m;
  endfunction
  localparam logic [BUS_W-1:0] ST_MASK = status_mask();

  logic       ch_space;
  logic [1:0] slot;
  reg_sel_e   rsel;
  logic [BUS_W-1:0] ch_rd [SLOT_MAX];
  logic [NREG-1:0]  pend_all [SLOT_MAX];
  logic [BUS_W-1:0] status_vec;
  logic unused_bits;

  assign ch_space    = !bus_addr[6];
  assign slot        = bus_addr[5:4];
  assign rsel        = reg_sel_e'(bus_addr[3:2]);
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:12]};

  for (genvar c = 0; c < SLOT_MAX; c++) begin : g_ch
    if (c < NUM_CH) begin : g_on
      logic [NREG-1:0]    hit, pend, apply;
      ctrl_t              sh_ctrl;
      logic [PRESC_W-1:0] sh_presc, ap_presc;
      logic [PER_W-1:0]   sh_per, ap_per, sh_duty, ap_duty;
      logic               ap_en, ap_inv, ap_autold, ap_stop;
      logic               ld_presc_p, ld_per_p;

      for (genvar k = 0; k < NREG; k++) begin : g_reg
        assign hit[k] = bus_wr && ch_space && (slot == 2'(c)) && (rsel == reg_sel_e'(k));
        pwm_duo_sync #(.LAT(SYNC_LAT)) u_sync (
          .clk(clk), .rst_n(rst_n), .start(hit[k]),
          .pending(pend[k]), .apply(apply[k])
        );
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sh_ctrl  <= '0;
          sh_presc <= '0;
          sh_per   <= '0;
          sh_duty  <= '0;
        end else begin
          if (hit[RG_CTRL])  sh_ctrl  <= ctrl_t'(bus_wdata[5:0]);
          if (hit[RG_PRESC]) sh_presc <= bus_wdata[PRESC_W-1:0];
          if (hit[RG_PER])   sh_per   <= bus_wdata[PER_W-1:0];
          if (hit[RG_DUTY])  sh_duty  <= bus_wdata[PER_W-1:0];
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          {ap_en, ap_inv, ap_autold, ap_stop} <= '0;
          ap_presc   <= '0;
          ap_per     <= '0;
          ap_duty    <= '0;
          ld_presc_p <= 1'b0;
          ld_per_p   <= 1'b0;
        end else begin
          ld_presc_p <= apply[RG_CTRL] && sh_ctrl.ld_presc;
          ld_per_p   <= apply[RG_CTRL] && sh_ctrl.ld_per;
          if (apply[RG_CTRL]) begin
            ap_en     <= sh_ctrl.en;
            ap_inv    <= sh_ctrl.inv;
            ap_autold <= sh_ctrl.autold;
            ap_stop   <= sh_ctrl.stop_now;
          end
          if (apply[RG_PRESC]) ap_presc <= sh_presc;
          if (apply[RG_PER])   ap_per   <= sh_per;
          if (apply[RG_DUTY])  ap_duty  <= sh_duty;
        end
      end

      pwm_duo_chan #(.PRESC_W(PRESC_W), .PER_W(PER_W)) u_chan (
        .clk(clk), .rst_n(rst_n),
        .en(ap_en), .inv(ap_inv), .autold(ap_autold), .stop_now(ap_stop),
        .presc_in(ap_presc), .per_in(ap_per), .duty_in(ap_duty),
        .ld_presc(ld_presc_p), .ld_per(ld_per_p),
        .pwm_o(pwm_out[c])
      );

      assign pend_all[c] = pend;

      always_comb begin
        ch_rd[c] = '0;
        unique case (rsel)
          RG_CTRL:  ch_rd[c][3:0]         = sh_ctrl[3:0];
          RG_PRESC: ch_rd[c][PRESC_W-1:0] = sh_presc;
          RG_PER:   ch_rd[c][PER_W-1:0]   = sh_per;
          RG_DUTY:  ch_rd[c][PER_W-1:0]   = sh_duty;
        endcase
      end
    end else begin : g_off
      assign ch_rd[c]    = '0;
      assign pend_all[c] = '0;
    end
  end

  always_comb begin
    status_vec = '0;
    for (int c = 0; c < SLOT_MAX; c++) status_vec[8*c +: NREG] = pend_all[c];
  end

  always_comb begin
    if (bus_addr == STATUS_ADDR) bus_rdata = status_vec;
    else if (ch_space)           bus_rdata = ch_rd[slot];
    else                         bus_rdata = '0;
  end

  // R2
  status_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == STATUS_ADDR) |-> ((bus_rdata & ~ST_MASK) == '0));
endmodule

// File: tb/pwm_duo_tb_top.sv
`timescale 1ns/1ps
module pwm_duo_tb_top;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  pwm_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_duo #(.NUM_CH(2), .SYNC_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wcyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwrite(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic cfg(int ch, int presc, int per, int duty, int ctrl);
    bwrite(7'(ch*16 + 4), presc);
    bwrite(7'(ch*16 + 8), per);
    bwrite(7'(ch*16 + 12), duty);
    bwrite(7'(ch*16), ctrl);
    wcyc(2*LAT + 4);
  endtask

  task automatic halt(int ch);
    bwrite(7'(ch*16), 32'h8);
    wcyc(LAT + 4);
  endtask

  task automatic count_high(int ch, int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[ch]) cnt++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    #1;
    chk(pwm_out == 2'b00, "R6 reset output", pwm_out, 0);
    bread(7'h40, d);
    chk(d == 0, "R3 reset status", d, 0);
    bread(7'h04, d);
    chk(d == 0, "R1 reset prescaler", d, 0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    bwrite(7'h04, 32'hFFFF_FFFF);
    bread(7'h04, d);
    chk(d == 32'h3FF, "R1 prescaler mask", d, 32'h3FF);
    bwrite(7'h08, 32'hFFFF_FFFF);
    bread(7'h08, d);
    chk(d == 32'hFFF, "R1 period mask", d, 32'hFFF);
    bwrite(7'h00, 32'h3C);
    bread(7'h00, d);
    chk(d == 32'hC, "R1 control strobes read zero", d, 32'hC);
    bwrite(7'h1C, 32'hABC);
    bread(7'h1C, d);
    chk(d == 32'hABC, "R1 ch1 duty", d, 32'hABC);
    bwrite(7'h00, 32'h8);
    wcyc(LAT + 4);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    bwrite(7'h14, 32'h5);
    bus_addr = 7'h40;
    for (int k = 0; k <= LAT; k++) begin
      #1 d = bus_rdata;
      chk(d[9] == (k < LAT), "R3 busy flag timing", d[9], k < LAT);
      chk((d & ~32'h200) == 0, "R3 only written flag set", d, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_wave();
    int c;
    cfg(0, 1, 4, 2, 1);
    count_high(0, 100, c);
    chk(c == 40, "R4 presc1 per4 duty2", c, 40);
    cfg(0, 0, 9, 3, 1);
    count_high(0, 100, c);
    chk(c == 30, "R4 presc0 per9 duty3", c, 30);
  endtask

  task automatic t_edges();
    int c;
    cfg(0, 1, 4, 0, 1);
    count_high(0, 100, c);
    chk(c == 0, "R5 duty zero", c, 0);
    cfg(0, 1, 4, 4095, 1);
    count_high(0, 100, c);
    chk(c == 100, "R5 duty above period", c, 100);
    cfg(0, 1, 4, 4, 1);
    count_high(0, 100, c);
    chk(c == 80, "R4 duty equals period", c, 80);
  endtask

  task automatic t_invert();
    int c;
    cfg(0, 1, 4, 2, 3);
    count_high(0, 100, c);
    chk(c == 60, "R6 inverted duty", c, 60);
    bwrite(7'h00, 32'hA);
    wcyc(LAT + 4);
    count_high(0, 20, c);
    chk(c == 20, "R6 idle inverted high", c, 20);
    bwrite(7'h00, 32'h8);
    wcyc(LAT + 4);
    count_high(0, 20, c);
    chk(c == 0, "R6 idle plain low", c, 0);
  endtask

  task automatic t_autoload();
    int runlen = 0, bad = 0, badlen = 0;
    bit started = 0, prev = 0, cur, seen4 = 0, seen6 = 0, dsel = 0;
    halt(0);
    cfg(0, 1, 4, 2, 5);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      cur = pwm_out[0];
      if (started && prev && !cur) begin
        if (runlen == 4) seen4 = 1;
        else if (runlen == 6) seen6 = 1;
        else begin bad++; badlen = runlen; end
      end
      if (cur && !prev) begin started = 1; runlen = 1; end
      else if (cur) runlen++;
      prev = cur;
      if (i % 43 == 0) begin
        bus_wr = 1'b1; bus_addr = 7'h0C; bus_wdata = dsel ? 32'd2 : 32'd3;
        dsel = !dsel;
      end else bus_wr = 1'b0;
    end
    bus_wr = 1'b0;
    chk(bad == 0, "R7 no truncated pulse", badlen, 4);
    chk(seen4 && seen6, "R7 both widths seen", {seen4, seen6}, 3);
  endtask

  task automatic t_stop();
    int c;
    halt(0);
    cfg(0, 0, 99, 4095, 1);
    wcyc(10);
    bwrite(7'h00, 32'h0);
    wcyc(LAT + 1);
    chk(pwm_out[0] == 1'b1, "R8 graceful stop keeps running", pwm_out[0], 1);
    c = 0;
    while (pwm_out[0] && c < 200) begin @(negedge clk); c++; end
    chk(c > 0 && c <= 100, "R8 graceful stop ends at rollover", c, 90);
    cfg(0, 0, 99, 4095, 1);
    wcyc(10);
    bwrite(7'h00, 32'h8);
    wcyc(LAT + 1);
    chk(pwm_out[0] == 1'b0, "R8 abrupt stop", pwm_out[0], 0);
  endtask

  task automatic t_load();
    int c = 0, o = 0;
    halt(0);
    cfg(1, 0, 199, 100, 5);
    bwrite(7'h18, 32'd9);
    bwrite(7'h1C, 32'd5);
    wcyc(LAT + 2);
    bwrite(7'h10, 32'h25);
    wcyc(LAT + 2);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwm_out[1]) c++;
      if (pwm_out[0]) o++;
    end
    chk(c == 10, "R9 period reload at once", c, 10);
    chk(o == 0, "R10 idle channel untouched", o, 0);
    bwrite(7'h14, 32'd1);
    wcyc(LAT + 2);
    bwrite(7'h10, 32'h15);
    wcyc(LAT + 2);
    count_high(1, 40, c);
    chk(c == 20, "R9 prescaler reload", c, 20);
    cfg(0, 1, 4, 2, 1);
    count_high(1, 40, c);
    chk(c == 20, "R10 ch1 unchanged by ch0", c, 20);
  endtask

  task automatic t_unimpl();
    logic [31:0] d;
    bwrite(7'h20, 32'h1);
    bus_addr = 7'h40;
    #1 d = bus_rdata;
    chk(d == 0, "R2 no flag for missing channel", d, 0);
    bread(7'h20, d);
    chk(d == 0, "R2 slot 2 reads zero", d, 0);
    bwrite(7'h34, 32'h3FF);
    bread(7'h34, d);
    chk(d == 0, "R2 slot 3 reads zero", d, 0);
    bread(7'h44, d);
    chk(d == 0, "R2 beyond status reads zero", d, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    wcyc(4);
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_pending();
    t_wave();
    t_edges();
    t_invert();
    t_autoload();
    t_stop();
    t_load();
    t_unimpl();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule